// File: doc/BRIEF.md
# External Multiplexed Bus Cycle Sequencer

This block produces the pin choreography of an 8-bit controller's external memory bus. It runs from the oscillator clock. Each machine cycle lasts twelve oscillator periods, made of two six-period slots. The low address byte and the data bytes share one 8-bit port. The high address byte has its own port. An address latch enable pulse tells external logic when to capture the low byte. Three active-low strobes mark program fetches, data reads and data writes.

The core offers one command per machine cycle. The block takes it at the end of the current machine cycle, during the period when `cmd_take` is high.

A fetch command reads two consecutive program bytes, one per slot. For each slot the block decides whether that byte comes from on-chip program memory or from the external bus. That choice uses the on-chip enable that was captured with the command and the slot address. A data read or data write uses the whole machine cycle. Its single long strobe takes the place of the second latch pulse. The bytes returned from the bus come back as one-period valid pulses.

Top module: `xbus_sequencer`

## Requirements
- R1: While `rst` is high, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `port_oe`=0, `cmd_take`=0 and both valid outputs are 0. After reset, period numbering starts at 0 in the first period. `cmd_take` is high only in period 11 of each twelve-period machine cycle. The command inputs present in that period apply to the next machine cycle.
- R2: The command code is `cmd_kind`=1 for a fetch, 2 for a read, 3 for a write and 0 for idle. In a fetch cycle, `ale` is high in the first two periods of each six-period slot, so it pulses twice per machine cycle. Slot 0 fetches `cmd_addr` and slot 1 fetches `cmd_addr`+1, wrapping modulo 2^16.
- R3: In an external fetch slot, `port_out` carries the slot address low byte with `port_oe`=1 for slot periods 0 to 2. `addr_hi` carries the slot address high byte for the whole slot. `psen_n` is low for slot periods 3 to 5, and `port_oe` is 0 during that time.
- R4: For an external fetch slot, `port_in` is sampled at the clock edge that ends slot period 5, which is where `psen_n` rises. `fetch_valid` is high with that byte on `fetch_byte` for the one following period.
- R5: A fetch slot is internal when the captured `onchip_prog_en` is 1 and the slot address is below `INT_LIMIT` (default 8192). In an internal slot, `prog_internal`=1, `psen_n` stays high, the port is not driven and no `fetch_valid` is produced, but `ale` still pulses. Every other fetch slot is external.
- R6: In a read or write cycle, `ale` is high only in periods 0 and 1. The pulse at period 6 is omitted. `psen_n` stays high for the whole machine cycle. `addr_hi` carries the data address high byte throughout.
- R7: In a read cycle, the low address byte is driven in periods 0 to 2 and the port is released from period 3 onward. `rd_n` is low in periods 5 to 10, which is three periods after `ale` falls and six periods long. `port_in` is sampled as `rd_n` rises, and `rdata_valid` is high in period 11 with that byte on `rdata`.
- R8: In a write cycle, the low address byte is driven in periods 0 to 2. `port_oe` is 0 in period 3. `cmd_wdata` is driven on `port_out` in periods 4 to 11, which is seven periods before `wr_n` rises. `wr_n` is low in periods 5 to 10.
- R9: An idle cycle produces no `ale` pulse and no strobe. The port is not driven and `addr_hi` is 0.
- R10: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time. No strobe is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per tick |
| rst | input | 1 | Synchronous active-high reset |
| cmd_kind | input | 2 | Next command: 0 idle, 1 fetch, 2 read, 3 write |
| cmd_addr | input | 16 | Program counter or data address for the next command |
| cmd_wdata | input | 8 | Write byte for a write command |
| onchip_prog_en | input | 1 | Permits on-chip program memory for fetches |
| cmd_take | output | 1 | High in the period whose closing edge captures the command |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| port_out | output | 8 | Shared address-low/data port, outgoing value (0 when not driven) |
| port_oe | output | 1 | Drive enable of the shared port |
| port_in | input | 8 | Shared port, incoming value |
| addr_hi | output | 8 | High address byte port |
| prog_internal | output | 1 | Current fetch slot uses on-chip program memory |
| fetch_valid | output | 1 | Fetched external program byte is valid |
| fetch_byte | output | 8 | Fetched external program byte |
| rdata_valid | output | 1 | Read data byte is valid |
| rdata | output | 8 | Byte returned by a data read |

## Verification
The latch enable, the strobes, the port drive and the high address are decoded from the registered period counter. Each of them is therefore due in the same period the counter reaches, and the reference model compares them in that period. A fetched byte is due one period after the last low `psen_n` period of its slot. Read data is due in period 11, one period after the last low `rd_n` period. The model holds each pending byte for exactly one step and compares it in the next step. All comparisons take place on the falling clock edge, half a period away from the edges that change the outputs. The bench models the external memory as a latch fed from `port_out` on `ale`, which also checks that the address placed on the port can be captured.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

    localparam int unsigned ADDR_W        = 16;
    localparam int unsigned DATA_W        = 8;
    localparam int unsigned HI_W          = ADDR_W - DATA_W;
    localparam int unsigned SLOT_PERIODS  = 6;
    localparam int unsigned SLOTS_PER_MC  = 2;
    localparam int unsigned MC_PERIODS    = SLOT_PERIODS * SLOTS_PER_MC;
    localparam int unsigned PHASE_W       = $clog2(MC_PERIODS);
    localparam int unsigned TPOS_W        = $clog2(SLOT_PERIODS);

    // period positions (within a slot for fetches, within the machine cycle for data)
    localparam int unsigned ALE_HIGH      = 2;   // ale high periods [0, ALE_HIGH)
    localparam int unsigned ADDR_DRIVE    = 3;   // low address on port [0, ADDR_DRIVE)
    localparam int unsigned PSEN_FALL     = 3;   // psen_n low [PSEN_FALL, SLOT_PERIODS)
    localparam int unsigned STROBE_FALL   = 5;   // rd_n / wr_n low [STROBE_FALL, STROBE_RISE)
    localparam int unsigned STROBE_RISE   = 11;
    localparam int unsigned WDATA_FROM    = 4;   // write byte on port [WDATA_FROM, MC_PERIODS)

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_FETCH = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e           kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                onchip_en;
    } bus_cmd_t;

    typedef struct packed {
        logic                ale;
        logic                psen_n;
        logic                rd_n;
        logic                wr_n;
        logic                port_oe;
        logic [DATA_W-1:0]   port_out;
        logic [HI_W-1:0]     addr_hi;
        logic                prog_int;
        logic                fetch_sample;
        logic                read_sample;
    } bus_pins_t;

    // true when position p lies in [lo, hi)
    function automatic logic in_span(input logic [PHASE_W-1:0] p,
                                     input int unsigned lo,
                                     input int unsigned hi);
        return (32'(p) >= lo) && (32'(p) < hi);
    endfunction

    function automatic logic [DATA_W-1:0] low_byte(input logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0];
    endfunction

    function automatic logic [HI_W-1:0] high_byte(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:DATA_W];
    endfunction

endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
    import xbus_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [PHASE_W-1:0] phase,
    output logic               slot_sel,
    output logic [PHASE_W-1:0] tpos,
    output logic               cycle_last
);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(MC_PERIODS - 1);
    localparam logic [PHASE_W-1:0] SLOT_LEN   = PHASE_W'(SLOT_PERIODS);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST_PHASE) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        slot_sel   = (phase >= SLOT_LEN);
        tpos       = slot_sel ? (phase - SLOT_LEN) : phase;
        cycle_last = (phase == LAST_PHASE);
    end

    // R1: the command window lasts exactly one period
    a_r1_take_single: assert property (@(posedge clk) disable iff (rst)
        cycle_last |=> !cycle_last);

endmodule

// File: rtl/xbus_cmd_reg.sv
module xbus_cmd_reg
    import xbus_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  bus_cmd_t next_cmd,
    output bus_cmd_t cur_cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cmd.kind      <= CMD_IDLE;
            cur_cmd.addr      <= '0;
            cur_cmd.wdata     <= '0;
            cur_cmd.onchip_en <= 1'b0;
        end else if (take) begin
            cur_cmd <= next_cmd;
        end
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_seq_pkg::*;
#(
    parameter int unsigned INT_LIMIT = 8192
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic               slot_sel,
    input  logic [PHASE_W-1:0] tpos,
    input  bus_cmd_t           cur_cmd,
    output bus_pins_t          pins
);
    logic [ADDR_W-1:0] slot_addr;
    logic              onchip;

    always_comb begin
        slot_addr = cur_cmd.addr + ADDR_W'(slot_sel);
        onchip    = cur_cmd.onchip_en && (32'(slot_addr) < INT_LIMIT);
    end

    always_comb begin
        pins              = '0;
        pins.psen_n       = 1'b1;
        pins.rd_n         = 1'b1;
        pins.wr_n         = 1'b1;
        unique case (cur_cmd.kind)
            CMD_FETCH: begin
                pins.ale      = in_span(tpos, 0, ALE_HIGH);
                pins.addr_hi  = high_byte(slot_addr);
                pins.prog_int = onchip;
                if (!onchip) begin
                    pins.port_oe      = in_span(tpos, 0, ADDR_DRIVE);
                    pins.port_out     = pins.port_oe ? low_byte(slot_addr) : '0;
                    pins.psen_n       = !in_span(tpos, PSEN_FALL, SLOT_PERIODS);
                    pins.fetch_sample = in_span(tpos, SLOT_PERIODS - 1, SLOT_PERIODS);
                end
            end
            CMD_READ: begin
                pins.ale         = in_span(phase, 0, ALE_HIGH);
                pins.addr_hi     = high_byte(cur_cmd.addr);
                pins.port_oe     = in_span(phase, 0, ADDR_DRIVE);
                pins.port_out    = pins.port_oe ? low_byte(cur_cmd.addr) : '0;
                pins.rd_n        = !in_span(phase, STROBE_FALL, STROBE_RISE);
                pins.read_sample = in_span(phase, STROBE_RISE - 1, STROBE_RISE);
            end
            CMD_WRITE: begin
                pins.ale      = in_span(phase, 0, ALE_HIGH);
                pins.addr_hi  = high_byte(cur_cmd.addr);
                if (in_span(phase, 0, ADDR_DRIVE)) begin
                    pins.port_oe  = 1'b1;
                    pins.port_out = low_byte(cur_cmd.addr);
                end else if (in_span(phase, WDATA_FROM, MC_PERIODS)) begin
                    pins.port_oe  = 1'b1;
                    pins.port_out = cur_cmd.wdata;
                end
                pins.wr_n     = !in_span(phase, STROBE_FALL, STROBE_RISE);
            end
            default: begin
                pins.ale = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_sample,
    input  logic              read_sample,
    input  logic [DATA_W-1:0] port_in,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_byte,
    output logic              rdata_valid,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_valid <= 1'b0;
            fetch_byte  <= '0;
            rdata_valid <= 1'b0;
            rdata       <= '0;
        end else begin
            fetch_valid <= fetch_sample;
            rdata_valid <= read_sample;
            if (fetch_sample) fetch_byte <= port_in;
            if (read_sample)  rdata      <= port_in;
        end
    end

    // R4: each fetched byte is reported for a single period
    a_r4_fetch_pulse: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> !fetch_valid);
    // R7: read data is reported for a single period
    a_r7_read_pulse: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_seq_pkg::*;
#(
    parameter int unsigned INT_LIMIT = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              onchip_prog_en,
    output logic              cmd_take,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    input  logic [DATA_W-1:0] port_in,
    output logic [HI_W-1:0]   addr_hi,
    output logic              prog_internal,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_byte,
    output logic              rdata_valid,
    output logic [DATA_W-1:0] rdata
);
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] tpos;
    logic               slot_sel;
    logic               cycle_last;
    bus_cmd_t           next_cmd;
    bus_cmd_t           cur_cmd;
    bus_pins_t          pins;

    always_comb begin
        next_cmd.kind      = cmd_kind_e'(cmd_kind);
        next_cmd.addr      = cmd_addr;
        next_cmd.wdata     = cmd_wdata;
        next_cmd.onchip_en = onchip_prog_en;
    end

    xbus_phase_ctr u_phase (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .slot_sel   (slot_sel),
        .tpos       (tpos),
        .cycle_last (cycle_last)
    );

    xbus_cmd_reg u_cmd (
        .clk      (clk),
        .rst      (rst),
        .take     (cycle_last),
        .next_cmd (next_cmd),
        .cur_cmd  (cur_cmd)
    );

    xbus_strobe_gen #(.INT_LIMIT(INT_LIMIT)) u_strobe (
        .phase    (phase),
        .slot_sel (slot_sel),
        .tpos     (tpos),
        .cur_cmd  (cur_cmd),
        .pins     (pins)
    );

    xbus_capture u_cap (
        .clk          (clk),
        .rst          (rst),
        .fetch_sample (pins.fetch_sample),
        .read_sample  (pins.read_sample),
        .port_in      (port_in),
        .fetch_valid  (fetch_valid),
        .fetch_byte   (fetch_byte),
        .rdata_valid  (rdata_valid),
        .rdata        (rdata)
    );

    always_comb begin
        cmd_take      = cycle_last && !rst;
        ale           = pins.ale;
        psen_n        = pins.psen_n;
        rd_n          = pins.rd_n;
        wr_n          = pins.wr_n;
        port_out      = pins.port_out;
        port_oe       = pins.port_oe;
        addr_hi       = pins.addr_hi;
        prog_internal = pins.prog_int;
    end

    // R10: strobes never overlap
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);
    // R10: no strobe while the address latch is open
    a_r10_ale_quiet: assert property (@(posedge clk) disable iff (rst)
        ale |-> (psen_n && rd_n && wr_n));
    // R2: latch pulse lasts two periods
    a_r2_ale_width: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> ($past(ale, 1) && $past(ale, 2)));
    // R3: program strobe low for three periods
    a_r3_psen_width: assert property (@(posedge clk) disable iff (rst)
        $rose(psen_n) |-> (!$past(psen_n, 2) && !$past(psen_n, 3) && $past(psen_n, 4)));
    // R3: port released while the program strobe is low
    a_r3_psen_release: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !port_oe);
    // R7: read strobe low for six periods, port released meanwhile
    a_r7_rd_width: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (!$past(rd_n, 6) && $past(rd_n, 7)));
    a_r7_rd_release: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !port_oe);
    // R8: write byte driven throughout the write strobe
    a_r8_wr_driven: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> port_oe);

endmodule

// File: tb/xbus_sequencer_tb.sv
module xbus_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cmd_kind;
    logic [15:0] cmd_addr;
    logic [7:0] cmd_wdata;
    logic       onchip_prog_en;
    logic       cmd_take, ale, psen_n, rd_n, wr_n, port_oe;
    logic [7:0] port_out, port_in, addr_hi, fetch_byte, rdata;
    logic       prog_internal, fetch_valid, rdata_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_sequencer dut_i (
        .clk(clk), .rst(rst), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .onchip_prog_en(onchip_prog_en),
        .cmd_take(cmd_take), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .port_out(port_out), .port_oe(port_oe), .port_in(port_in),
        .addr_hi(addr_hi), .prog_internal(prog_internal),
        .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
        .rdata_valid(rdata_valid), .rdata(rdata)
    );

    // command queue
    int q_kind[$];
    int q_addr[$];
    int q_wd[$];
    int q_en[$];

    // reference model state
    int k;
    int c_kind, c_addr, c_wd, c_en;
    bit pend_f, pend_r;
    int pend_fb, pend_rb;
    logic [7:0] latched_lo;

    function automatic int mem_byte(input int a);
        return ((a * 3) ^ (a >> 8) ^ 8'h5A) & 8'hFF;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s period=%0d actual=%0h expected=%0h", tag, what, k, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int wd, input int en);
        q_kind.push_back(kind); q_addr.push_back(addr);
        q_wd.push_back(wd);     q_en.push_back(en);
    endtask

    task automatic model_step();
        int e_ale, e_psen, e_rd, e_wr, e_oe, e_out, e_hi, e_int;
        int s, t, a;
        bit intl, nf, nr;
        int nfb;
        string tg;
        e_ale = 0; e_psen = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_out = 0; e_hi = 0; e_int = 0;
        nf = 0; nr = 0; nfb = 0; intl = 0;
        s = k / 6; t = k % 6;
        tg = "R9";
        case (c_kind)
            1: begin
                a = (c_addr + s) & 16'hFFFF;
                intl = (c_en != 0) && (a < 8192);
                tg = intl ? "R5" : "R3";
                e_ale = (t < 2); e_hi = a >> 8; e_int = intl;
                if (!intl) begin
                    e_oe = (t < 3); e_out = a & 8'hFF; e_psen = (t >= 3) ? 0 : 1;
                    nf = (t == 5); nfb = mem_byte(a);
                end
            end
            2: begin
                tg = "R7";
                e_ale = (k < 2); e_hi = c_addr >> 8; e_oe = (k < 3); e_out = c_addr & 8'hFF;
                e_rd = (k >= 5 && k <= 10) ? 0 : 1;
                nr = (k == 10);
            end
            3: begin
                tg = "R8";
                e_ale = (k < 2); e_hi = c_addr >> 8; e_oe = (k != 3);
                e_out = (k < 3) ? (c_addr & 8'hFF) : c_wd;
                e_wr = (k >= 5 && k <= 10) ? 0 : 1;
            end
            default: ;
        endcase
        chk((c_kind == 1) ? "R2" : ((c_kind == 0) ? "R9" : "R6"), "ale", ale, e_ale);
        chk((c_kind >= 2) ? "R6" : tg, "psen_n", psen_n, e_psen);
        chk("R7", "rd_n", rd_n, e_rd);
        chk("R8", "wr_n", wr_n, e_wr);
        chk(tg, "port_oe", port_oe, e_oe);
        if (e_oe != 0) chk(tg, "port_out", port_out, e_out);
        chk((c_kind >= 2) ? "R6" : tg, "addr_hi", addr_hi, e_hi);
        chk("R5", "prog_internal", prog_internal, e_int);
        chk("R1", "cmd_take", cmd_take, (k == 11));
        chk("R10", "strobe overlap", ($countones({!psen_n, !rd_n, !wr_n}) <= 1), 1);
        chk("R4", "fetch_valid", fetch_valid, pend_f);
        if (pend_f) chk("R4", "fetch_byte", fetch_byte, pend_fb);
        chk("R7", "rdata_valid", rdata_valid, pend_r);
        if (pend_r) chk("R7", "rdata", rdata, pend_rb);
        pend_f = nf; pend_fb = nfb;
        pend_r = nr; pend_rb = mem_byte(c_addr & 16'hFFFF);

        // external memory: latch low byte on ale, answer strobes
        if (ale && port_oe) latched_lo = port_out;
        if (!psen_n || !rd_n) port_in = 8'(mem_byte({addr_hi, latched_lo}));
        else port_in = 8'h00;

        if (k == 11) begin
            if (q_kind.size() > 0) begin
                c_kind = q_kind.pop_front(); c_addr = q_addr.pop_front();
                c_wd = q_wd.pop_front();     c_en = q_en.pop_front();
            end else begin
                c_kind = 0; c_addr = 0; c_wd = 0; c_en = 0;
            end
            cmd_kind = 2'(c_kind); cmd_addr = 16'(c_addr);
            cmd_wdata = 8'(c_wd); onchip_prog_en = (c_en != 0);
            k = 0;
        end else begin
            k = k + 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_kind = 2'd0; cmd_addr = 16'h0; cmd_wdata = 8'h0;
        onchip_prog_en = 1'b0; port_in = 8'h00; latched_lo = 8'h00;
        k = 0; c_kind = 0; c_addr = 0; c_wd = 0; c_en = 0;
        pend_f = 0; pend_r = 0; pend_fb = 0; pend_rb = 0;

        push(1, 16'h0100, 0, 0);     // external fetch, both slots
        push(1, 16'h0100, 0, 1);     // internal fetch, both slots
        push(1, 16'h1FFF, 0, 1);     // slot 0 internal, slot 1 at the limit external
        push(2, 16'h2345, 0, 0);     // read
        push(3, 16'h3456, 8'hA5, 0); // write
        push(1, 16'hFFFF, 0, 0);     // address wrap between slots
        push(0, 16'h1234, 8'h77, 1); // idle
        push(3, 16'h00FF, 8'h3C, 1); // write then read back to back
        push(2, 16'h8001, 0, 0);
        push(1, 16'h4000, 0, 1);     // enable set but address above limit
        push(2, 16'h0000, 0, 1);

        repeat (3) begin
            @(negedge clk);
            // R1 reset state
            chk("R1", "reset ale", ale, 0);
            chk("R1", "reset psen_n", psen_n, 1);
            chk("R1", "reset rd_n", rd_n, 1);
            chk("R1", "reset wr_n", wr_n, 1);
            chk("R1", "reset port_oe", port_oe, 0);
            chk("R1", "reset cmd_take", cmd_take, 0);
            chk("R1", "reset fetch_valid", fetch_valid, 0);
            chk("R1", "reset rdata_valid", rdata_valid, 0);
        end
        rst = 1'b0;
        model_step();
        while (q_kind.size() > 0 || k != 0) begin
            @(negedge clk);
            model_step();
        end
        repeat (14) begin
            @(negedge clk);
            model_step();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule